// File: doc/BRIEF.md
# Counting Interrupt Controller

This block collects a parameterised set of level-sensitive interrupt lines and presents them to a processor through a word-addressed register window of 4 KB. Every line has its own enable bit. The block keeps a live tally of lines that are both high and enabled. It raises a single parent interrupt while that tally is nonzero. It also reports the lowest-numbered qualifying line, which is the line software should service first.

Software does not write bitmasks. It turns one line on or off by writing that line's index to a dedicated word, and it can switch every line off with one write to a third word. Reads come back one clock after the request. The interrupt lines are sampled on every clock. A level change and a register write that fall in the same cycle both take effect.

The register words are selected by address bits [11:2]:

| Word | Access | Purpose |
|------|--------|---------|
| 0 | read | fixed identification constant |
| 1 | read | pending tally |
| 2 | read | lowest qualifying line index |
| 3 | write | disable every line |
| 4 | write | disable the line whose index is written |
| 5 | write | enable the line whose index is written |

Top module: `cnt_irq_ctrl`

## Requirements
- R1: After reset all enable bits and all recorded levels are clear, the pending tally reads 0 and `irq_out` is low.
- R2: A read of word 0 returns the parameter `ID_VALUE`.
- R3: A read of word 2 returns the lowest line index that is both high and enabled, or 32'hFFFFFFFF when no line qualifies.
- R4: A read of word 1 returns the number of lines that are both high and enabled. The tally reflects an input change one clock after the change is sampled. It can reach `N_LINES`.
- R5: Any write to word 3 clears every enable bit, so the tally drops to 0. Lines enabled later count alone.
- R6: Writing index k to word 4 disables line k and removes it from the tally if it was high. Writing the index of a line that is already disabled changes nothing.
- R7: Writing index k to word 5 enables line k, and the line counts at once if its input is high. Writing the index of a line that is already enabled changes nothing.
- R8: A write to word 4 or word 5 whose full 32-bit value is greater than or equal to `N_LINES` is ignored. This holds even when the low bits of that value name a valid line.
- R9: A level change on a disabled line does not alter the tally, but the level is recorded, so the line counts as soon as it is enabled.
- R10: `irq_out` is high exactly when the pending tally is nonzero.
- R11: A read of any word above 5 returns 0 and sets `bus_err` for exactly one cycle. Reads of words 3 to 5 return 0 without an error. Writes to words 0 to 2 and to words above 5 change nothing.
- R12: When a line changes level in the same cycle as an enable or disable write, both updates are applied.
- R13: Only address bits [11:2] select a word. Bits [1:0] and bits above 11 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| irq_in | input | N_LINES | interrupt line levels |
| bus_en | input | 1 | access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | byte address; bits [11:2] select the word |
| bus_wdata | input | 32 | write data (line index for words 4 and 5) |
| bus_rdata | output | 32 | read data, valid the cycle after a read |
| bus_err | output | 1 | one-cycle pulse after a read of an undefined word |
| irq_out | output | 1 | parent interrupt request |

## Verification
The tally and the service index are tried with several input patterns, and each one separates a different fault:

- A few scattered high lines with nothing enabled shows that a level alone never counts.
- Enabling lines one by one, out of index order, separates "lowest qualifying index" from "most recently enabled".
- Dropping and restoring a single enabled line, while a disabled line toggles, separates level tracking from enable tracking.
- A write and a level change in the same cycle exposes any design that lets one update mask the other.
- Every line high and enabled checks the tally at its full width.
- Only the top line left high checks the upper end of the priority scan.
- Out-of-range index values whose low bits alias line 0 expose a truncated range compare.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int unsigned BUS_W = 32;
    localparam logic [BUS_W-1:0] NO_LINE_CODE = '1;

    typedef enum logic [9:0] {
        RW_IDENT  = 10'd0,
        RW_COUNT  = 10'd1,
        RW_NEXT   = 10'd2,
        RW_CLRALL = 10'd3,
        RW_OFF    = 10'd4,
        RW_ON     = 10'd5
    } reg_word_e;

endpackage

// File: rtl/cic_line_bank.sv
module cic_line_bank #(
    parameter int unsigned N_LINES = 64,
    localparam int unsigned IW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines_in,
    input  logic               set_on,
    input  logic               set_off,
    input  logic               clr_all,
    input  logic [IW-1:0]      sel_idx,
    output logic [N_LINES-1:0] level_q,
    output logic [N_LINES-1:0] en_q,
    output logic [N_LINES-1:0] level_nx,
    output logic [N_LINES-1:0] en_nx
);

    assign level_nx = lines_in;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic hit;
        assign hit = (sel_idx == IW'(g));

        always_comb begin
            if (clr_all)
                en_nx[g] = 1'b0;
            else if (set_on && hit)
                en_nx[g] = 1'b1;
            else if (set_off && hit)
                en_nx[g] = 1'b0;
            else
                en_nx[g] = en_q[g];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g]    <= 1'b0;
                level_q[g] <= 1'b0;
            end else begin
                en_q[g]    <= en_nx[g];
                level_q[g] <= level_nx[g];
            end
        end
    end

    // R7: an enable write leaves the named line enabled
    p_enable_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_on && !clr_all) |=> en_q[$past(sel_idx)]);

    // R6: a disable write leaves the named line disabled
    p_disable_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_off && !clr_all) |=> !en_q[$past(sel_idx)]);

endmodule

// File: rtl/cic_tally.sv
module cic_tally #(
    parameter int unsigned N_LINES = 64,
    localparam int unsigned CW = $clog2(N_LINES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] active_nx,
    output logic [CW-1:0]      count_q
);

    logic [CW-1:0] sum;

    always_comb begin
        sum = '0;
        for (int i = 0; i < N_LINES; i++)
            sum = sum + CW'(active_nx[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= sum;
    end

    // R4: the tally never exceeds the number of lines
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(N_LINES));

endmodule

// File: rtl/cic_lowest.sv
module cic_lowest #(
    parameter int unsigned N_LINES = 64,
    localparam int unsigned IW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] active,
    output logic               has_any,
    output logic [IW-1:0]      low_idx
);

    always_comb begin
        has_any = 1'b0;
        low_idx = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (active[i]) begin
                has_any = 1'b1;
                low_idx = IW'(i);
            end
        end
    end

    // R3: a reported line is itself active
    p_pick_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        has_any |-> active[low_idx]);

    // R3: the none indication only occurs with no active line
    p_none_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !has_any |-> (active == '0));

    // R3: no active line sits below the reported one
    p_none_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
        has_any |-> ((active & ((N_LINES'(1) << low_idx) - N_LINES'(1))) == '0));

endmodule

// File: rtl/cnt_irq_ctrl.sv
module cnt_irq_ctrl
    import cic_pkg::*;
#(
    parameter int unsigned     N_LINES  = 64,
    parameter logic [31:0]     ID_VALUE = 32'hC1C0_0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               bus_en,
    input  logic               bus_wr,
    input  logic [31:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_err,
    output logic               irq_out
);

    localparam int unsigned IW = (N_LINES > 1) ? $clog2(N_LINES) : 1;
    localparam int unsigned CW = $clog2(N_LINES + 1);

    logic [9:0]         word;
    logic               idx_ok;
    logic               wr_on, wr_off, wr_clr;
    logic               unused_addr_bits;
    logic [N_LINES-1:0] level_q, en_q, level_nx, en_nx;
    logic [CW-1:0]      count_q;
    logic               has_any;
    logic [IW-1:0]      low_idx;
    logic [31:0]        rd_mux;
    logic               rd_bad;

    assign word             = bus_addr[11:2];
    assign unused_addr_bits = ^{bus_addr[31:12], bus_addr[1:0]};
    assign idx_ok           = (bus_wdata < 32'(N_LINES));

    always_comb begin
        wr_on  = 1'b0;
        wr_off = 1'b0;
        wr_clr = 1'b0;
        if (bus_en && bus_wr) begin
            case (word)
                RW_CLRALL: wr_clr = 1'b1;
                RW_OFF:    wr_off = idx_ok;
                RW_ON:     wr_on  = idx_ok;
                default:   ;
            endcase
        end
    end

    cic_line_bank #(.N_LINES(N_LINES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (irq_in),
        .set_on   (wr_on),
        .set_off  (wr_off),
        .clr_all  (wr_clr),
        .sel_idx  (bus_wdata[IW-1:0]),
        .level_q  (level_q),
        .en_q     (en_q),
        .level_nx (level_nx),
        .en_nx    (en_nx)
    );

    cic_tally #(.N_LINES(N_LINES)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_nx (level_nx & en_nx),
        .count_q   (count_q)
    );

    cic_lowest #(.N_LINES(N_LINES)) u_lowest (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (level_q & en_q),
        .has_any (has_any),
        .low_idx (low_idx)
    );

    always_comb begin
        rd_mux = '0;
        rd_bad = 1'b0;
        case (word)
            RW_IDENT:                 rd_mux = ID_VALUE;
            RW_COUNT:                 rd_mux = 32'(count_q);
            RW_NEXT:                  rd_mux = has_any ? 32'(low_idx) : NO_LINE_CODE;
            RW_CLRALL, RW_OFF, RW_ON: rd_mux = '0;
            default:                  rd_bad = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= bus_en && !bus_wr && rd_bad;
            if (bus_en && !bus_wr)
                bus_rdata <= rd_mux;
        end
    end

    assign irq_out = (count_q != '0);

    // R5: clearing all enables empties the tally and drops the request
    p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && word == RW_CLRALL) |=> (count_q == '0 && !irq_out));

    // R8: out-of-range index writes leave every enable untouched
    p_oob_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && (word == RW_ON || word == RW_OFF)
         && bus_wdata >= 32'(N_LINES)) |=> $stable(en_q));

    // R11: undefined reads return zero with an error pulse
    p_undef_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_wr && word > 10'd5) |=> (bus_err && bus_rdata == '0));

    // R11: writes never raise the error flag
    p_write_no_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr) |=> !bus_err);

endmodule

// File: tb/cnt_irq_ctrl_tb.sv
module cnt_irq_ctrl_tb;

    localparam int unsigned N = 64;
    localparam logic [31:0] ID = 32'hC1C0_0001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          bus_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_err;
    logic          irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [N-1:0] en_m = '0;

    always #5 clk = ~clk;

    cnt_irq_ctrl #(.N_LINES(N), .ID_VALUE(ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_en(bus_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata; e = bus_err;
    endtask

    task automatic set_lines(input logic [N-1:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_cur();
        for (int i = 0; i < N; i++)
            if (irq_in[i] && en_m[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    task automatic check_state(input string req);
        logic [31:0] d; logic e;
        int exp_cnt;
        exp_cnt = $countones(irq_in & en_m);
        rd(32'h4, d, e);
        chk({req, " tally"}, d, 32'(exp_cnt));
        chk("R10 irq_out", {31'b0, irq_out}, {31'b0, exp_cnt != 0});
        rd(32'h8, d, e);
        chk({req, " next index"}, d, exp_cur());
    endtask

    task automatic t_reset();
        chk("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);
        check_state("R1");
    endtask

    task automatic t_ident();
        logic [31:0] d; logic e;
        rd(32'h0, d, e);
        chk("R2 ident", d, ID);
        rd(32'h7650_0003, d, e);
        chk("R13 ident alias", d, ID);
        rd(32'hABCD_F004, d, e);
        chk("R13 high bits ignored", d, 32'h0);
    endtask

    task automatic t_enable();
        set_lines((64'h1 << 5) | (64'h1 << 9) | (64'h1 << 63));
        check_state("R9 levels alone");
        wr(32'h14, 32'd9);  en_m[9] = 1'b1;
        check_state("R7 enable 9");
        wr(32'h14, 32'd63); en_m[63] = 1'b1;
        wr(32'h14, 32'd5);  en_m[5] = 1'b1;
        check_state("R3 R7 three enabled");
        wr(32'h14, 32'd9);
        check_state("R7 re-enable no effect");
    endtask

    task automatic t_disable();
        wr(32'h10, 32'd5);  en_m[5] = 1'b0;
        check_state("R6 disable 5");
        wr(32'h10, 32'd5);
        wr(32'h10, 32'd0);
        check_state("R6 disable already off");
    endtask

    task automatic t_oob();
        set_lines(irq_in | 64'h1);
        wr(32'h14, 32'd64);
        wr(32'h14, 32'h0000_0100);
        check_state("R8 enable out of range");
        wr(32'h14, 32'd0);  en_m[0] = 1'b1;
        check_state("R7 enable 0");
        wr(32'h10, 32'd64);
        wr(32'h10, 32'hFFFF_FFC0);
        check_state("R8 disable out of range");
        wr(32'h10, 32'd0);  en_m[0] = 1'b0;
    endtask

    task automatic t_levels();
        set_lines(irq_in & ~(64'h1 << 9));
        check_state("R4 drop line 9");
        set_lines(irq_in | (64'h1 << 9));
        check_state("R4 restore line 9");
        set_lines(irq_in | (64'h1 << 7));
        check_state("R9 disabled line rises");
        wr(32'h14, 32'd7);  en_m[7] = 1'b1;
        check_state("R9 recorded level counts");
        wr(32'h10, 32'd7);  en_m[7] = 1'b0;
        set_lines(irq_in & ~(64'h1 << 7));
    endtask

    task automatic t_simul();
        @(negedge clk);
        irq_in = (irq_in | (64'h1 << 7)) & ~(64'h1 << 63);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 32'h14; bus_wdata = 32'd7;
        en_m[7] = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
        chk("R12 irq_out", {31'b0, irq_out}, 32'h1);
        check_state("R12 write with level change");
    endtask

    task automatic t_clear_all();
        wr(32'hC, 32'h0);  en_m = '0;
        chk("R5 irq_out low", {31'b0, irq_out}, 32'h0);
        check_state("R5 cleared");
        wr(32'h14, 32'd9); en_m[9] = 1'b1;
        check_state("R5 only new enable counts");
    endtask

    task automatic t_undef();
        logic [31:0] d; logic e;
        rd(32'h18, d, e);
        chk("R11 undef data", d, 32'h0);
        chk("R11 undef err", {31'b0, e}, 32'h1);
        @(negedge clk);
        chk("R11 err is a pulse", {31'b0, bus_err}, 32'h0);
        rd(32'hFFC, d, e);
        chk("R11 top word err", {31'b0, e}, 32'h1);
        rd(32'hC, d, e);
        chk("R11 write-only read data", d, 32'h0);
        chk("R11 write-only read no err", {31'b0, e}, 32'h0);
        wr(32'h4, 32'd40);
        wr(32'h0, 32'd0);
        wr(32'h8, 32'd3);
        wr(32'h20, 32'd3);
        check_state("R11 ignored writes");
        rd(32'h0, d, e);
        chk("R11 ident kept", d, ID);
    endtask

    task automatic t_full();
        for (int i = 0; i < N; i++) begin
            wr(32'h14, 32'(i));
            en_m[i] = 1'b1;
        end
        set_lines('1);
        check_state("R4 all lines");
        set_lines(64'h1 << 63);
        check_state("R3 top line only");
        set_lines('0);
        check_state("R3 none active");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_enable();
        t_disable();
        t_oob();
        t_levels();
        t_simul();
        t_clear_all();
        t_undef();
        t_full();
        finish_run();
    end

endmodule